// File: doc/BRIEF.md
# Clock Holdover History Controller

This block decides how a network-element slave clock is steered. When any external timing reference is healthy, the clock tracks it, and the lowest-indexed healthy reference always wins. While the block tracks one reference without interruption, it records the oscillator's frequency-control word once every `TICK_DIV` one-second ticks. It keeps a running average of up to `WIN` samples, which at the default settings is roughly one day of history.

When every reference disappears, the block chooses between two modes. If the history is deep enough, it enters holdover and drives the averaged word. If it is not, it drops straight to free-run and drives a fixed nominal word.

Any change of tracked reference discards the history. A short stay on a new reference followed by total loss therefore ends in free-run, not holdover. The averaging is done by an accumulator and a saturating counter. A bit-serial divider turns them into the mean a few tens of cycles after each capture.

Top module: `holdover_ctrl`

## Requirements
- R1: After reset, `mode` is 0 (free-run), `sel_ref` is 0, `freq_out` equals `NOMINAL`, and the history is empty.
- R2: Mode encoding is 0 = free-run, 1 = tracking, 2 = holdover. One cycle after any bit of `ref_ok` is high, `mode` is 1 and `sel_ref` holds the lowest index whose bit is set, so bit 0 has top priority.
- R3: If the tracked reference drops while another stays valid, `sel_ref` moves to the remaining valid reference on the next cycle and `mode` stays 1.
- R4: While tracking, `freq_out` repeats `freq_in` with one cycle of latency. A sample of `freq_in` is captured on every `TICK_DIV`-th tick seen during uninterrupted tracking of one reference. Ticks seen outside tracking capture nothing.
- R5: Whenever the reference about to be tracked differs from the one last tracked, the history is cleared before collection restarts. This includes a return from holdover or free-run.
- R6: When all references drop while tracking and at least `MIN_SAMPLES` samples are stored, `mode` becomes 2 and `freq_out` becomes floor(sum/count) of the stored samples.
- R7: When all references drop while tracking and fewer than `MIN_SAMPLES` samples are stored, `mode` becomes 0 and `freq_out` becomes `NOMINAL`.
- R8: While no reference is valid, holdover and free-run persist, and `freq_out` stays constant whatever `freq_in` and `tick_1s` do.
- R9: Once `WIN` samples are stored, the count stops rising. Each later capture subtracts the current mean from the sum before adding the new sample.
- R10: Returning to the same reference that was last tracked keeps the existing history, and new samples add to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_ok | input | NREF | Per-reference valid flags, bit 0 highest priority |
| freq_in | input | FW | Live frequency-control word from the disciplined oscillator |
| tick_1s | input | 1 | One-cycle pulse per second |
| mode | output | 2 | 0 free-run, 1 tracking, 2 holdover |
| sel_ref | output | $clog2(NREF) | Index of the reference tracked or last tracked |
| freq_out | output | FW | Frequency word driven to the oscillator |

## Verification
On every cycle, the bound checker enforces the following:
- the one-cycle reaction of `mode` and `sel_ref` to `ref_ok`;
- the priority of reference 0;
- that holdover is entered only from tracking;
- the frozen output in holdover and the nominal word in free-run;
- that the sample count stays within `WIN`.

Other behaviour only the bench scenarios can show, by comparing against its own accumulator model:
- whether holdover or free-run is chosen on total loss;
- the averaged value;
- clearing on a change of reference and keeping history on a return to the same one;
- the saturated update after `WIN` samples.

// File: rtl/hold_pkg.sv
package hold_pkg;
  typedef enum logic [1:0] {
    MODE_FREE  = 2'd0,
    MODE_TRACK = 2'd1,
    MODE_HOLD  = 2'd2
  } clk_mode_e;
endpackage

// File: rtl/hold_ref_pick.sv
// Priority pick: lowest index among valid references wins.
module hold_ref_pick #(
  parameter int NREF = 2,
  parameter int SW   = 1
) (
  input  logic [NREF-1:0] ok,
  output logic            any,
  output logic [SW-1:0]   pick
);
  always_comb begin
    any  = |ok;
    pick = '0;
    for (int i = NREF - 1; i >= 0; i--) begin
      if (ok[i]) pick = SW'(i);
    end
  end
endmodule

// File: rtl/hold_tick_div.sv
// Divides the one-second tick down to the capture interval while tracking.
module hold_tick_div #(
  parameter int DIV = 9
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic tick,
  output logic fire
);
  localparam int TW = (DIV > 1) ? $clog2(DIV) : 1;

  generate
    if (DIV == 1) begin : g_direct
      logic unused_ok;
      assign unused_ok = clk ^ rst;
      assign fire = run & tick;
    end else begin : g_count
      logic [TW-1:0] cnt;
      always_ff @(posedge clk) begin
        if (rst || !run) begin
          cnt <= '0;
        end else if (tick) begin
          cnt <= (cnt == TW'(DIV - 1)) ? '0 : cnt + 1'b1;
        end
      end
      assign fire = run & tick & (cnt == TW'(DIV - 1));
    end
  endgenerate
endmodule

// File: rtl/hold_history.sv
// Frequency history: accumulator, saturating count and a bit-serial mean divider.
module hold_history #(
  parameter int FW  = 24,
  parameter int WIN = 9600,
  parameter int CW  = $clog2(WIN + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          cap,
  input  logic [FW-1:0] sample,
  output logic [CW-1:0] count,
  output logic [FW-1:0] mean
);
  localparam int AW = FW + CW;
  localparam int QW = FW + 1;
  localparam int RW = CW + 1;
  localparam int IW = $clog2(QW + 1);

  logic [AW-1:0] acc;
  logic [CW-1:0] cnt;
  logic [FW-1:0] mean_q;
  logic          start_q;
  logic          busy;
  logic [RW-1:0] rem;
  logic [QW-1:0] dvd;
  logic [QW-1:0] quo;
  logic [IW-1:0] itr;

  // accumulator and saturating sample count
  always_ff @(posedge clk) begin
    if (rst || clr) begin
      acc <= '0;
      cnt <= '0;
    end else if (cap) begin
      if (cnt < CW'(WIN)) begin
        acc <= acc + AW'(sample);
        cnt <= cnt + 1'b1;
      end else begin
        acc <= acc - AW'(mean_q) + AW'(sample);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) start_q <= 1'b0;
    else     start_q <= cap & ~clr;
  end

  // one restoring-division step per cycle
  logic [RW-1:0] shl;
  logic          ge;
  logic [RW-1:0] rem_n;
  logic [QW-1:0] quo_n;

  always_comb begin
    shl   = {rem[RW-2:0], dvd[QW-1]};
    ge    = (shl >= {1'b0, cnt});
    rem_n = ge ? (shl - {1'b0, cnt}) : shl;
    quo_n = {quo[QW-2:0], ge};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      rem    <= '0;
      dvd    <= '0;
      quo    <= '0;
      itr    <= '0;
      mean_q <= '0;
    end else if (clr) begin
      busy <= 1'b0;
      itr  <= '0;
    end else if (start_q) begin
      busy <= 1'b1;
      rem  <= RW'(acc[AW-1:QW]);
      dvd  <= acc[QW-1:0];
      quo  <= '0;
      itr  <= IW'(QW);
    end else if (busy) begin
      rem <= rem_n;
      dvd <= dvd << 1;
      quo <= quo_n;
      itr <= itr - 1'b1;
      if (itr == IW'(1)) begin
        busy   <= 1'b0;
        mean_q <= quo_n[QW-1] ? '1 : quo_n[FW-1:0];
      end
    end
  end

  assign count = cnt;
  assign mean  = mean_q;
endmodule

// File: rtl/holdover_ctrl.sv
module holdover_ctrl
  import hold_pkg::*;
#(
  parameter int          NREF        = 2,
  parameter int          FW          = 24,
  parameter int          TICK_DIV    = 9,
  parameter int          WIN         = 9600,
  parameter int          MIN_SAMPLES = 10,
  parameter logic [FW-1:0] NOMINAL   = FW'(1) << (FW - 1)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [NREF-1:0]         ref_ok,
  input  logic [FW-1:0]           freq_in,
  input  logic                    tick_1s,
  output logic [1:0]              mode,
  output logic [$clog2(NREF)-1:0] sel_ref,
  output logic [FW-1:0]           freq_out
);
  localparam int SW = $clog2(NREF);
  localparam int CW = $clog2(WIN + 1);

  clk_mode_e     mode_q, mode_n;
  logic [SW-1:0] sel_q;
  logic [FW-1:0] freq_q, freq_n;
  logic          any_ok;
  logic [SW-1:0] pick;
  logic          switch_ref;
  logic          track_now;
  logic          cap;
  logic [CW-1:0] hist_cnt;
  logic [FW-1:0] hist_mean;
  logic          qualified;

  hold_ref_pick #(.NREF(NREF), .SW(SW)) u_pick (
    .ok  (ref_ok),
    .any (any_ok),
    .pick(pick)
  );

  assign switch_ref = any_ok && (pick != sel_q);
  assign track_now  = any_ok && (mode_q == MODE_TRACK) && !switch_ref;

  hold_tick_div #(.DIV(TICK_DIV)) u_div (
    .clk (clk),
    .rst (rst),
    .run (track_now),
    .tick(tick_1s),
    .fire(cap)
  );

  hold_history #(.FW(FW), .WIN(WIN), .CW(CW)) u_hist (
    .clk   (clk),
    .rst   (rst),
    .clr   (switch_ref),
    .cap   (cap),
    .sample(freq_in),
    .count (hist_cnt),
    .mean  (hist_mean)
  );

  assign qualified = (hist_cnt >= CW'(MIN_SAMPLES));

  always_comb begin
    mode_n = mode_q;
    if (any_ok) begin
      mode_n = MODE_TRACK;
    end else if (mode_q == MODE_TRACK) begin
      mode_n = qualified ? MODE_HOLD : MODE_FREE;
    end
  end

  always_comb begin
    unique case (mode_n)
      MODE_TRACK: freq_n = freq_in;
      MODE_HOLD:  freq_n = (mode_q == MODE_HOLD) ? freq_q : hist_mean;
      default:    freq_n = NOMINAL;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= MODE_FREE;
      sel_q  <= '0;
      freq_q <= NOMINAL;
    end else begin
      mode_q <= mode_n;
      freq_q <= freq_n;
      if (any_ok) sel_q <= pick;
    end
  end

  assign mode     = mode_q;
  assign sel_ref  = sel_q;
  assign freq_out = freq_q;
endmodule

// File: rtl/holdover_ctrl_chk.sv
module holdover_ctrl_chk #(
  parameter int            NREF    = 2,
  parameter int            FW      = 24,
  parameter int            WIN     = 9600,
  parameter int            CW      = 14,
  parameter logic [FW-1:0] NOMINAL = '0
) (
  input logic                    clk,
  input logic                    rst,
  input logic [NREF-1:0]         ref_ok,
  input logic [1:0]              mode,
  input logic [$clog2(NREF)-1:0] sel_ref,
  input logic [FW-1:0]           freq_out,
  input logic [CW-1:0]           hist_cnt
);
  // R2
  track_follow_chk: assert property (@(posedge clk) disable iff (rst)
    (|ref_ok) |=> (mode == 2'd1));

  // R2
  prio_chk: assert property (@(posedge clk) disable iff (rst)
    ref_ok[0] |=> (sel_ref == '0));

  // R6
  hold_entry_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'd2 && $past(mode) != 2'd2) |-> ($past(mode) == 2'd1));

  // R8
  no_ref_stay_chk: assert property (@(posedge clk) disable iff (rst)
    (!(|ref_ok) && mode != 2'd1) |=> $stable(mode) && $stable(freq_out));

  // R7
  free_nominal_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'd0) |-> (freq_out == NOMINAL));

  // R9
  win_bound_chk: assert property (@(posedge clk) disable iff (rst)
    hist_cnt <= CW'(WIN));

  // R2
  mode_legal_chk: assert property (@(posedge clk) disable iff (rst)
    mode != 2'd3);
endmodule

bind holdover_ctrl holdover_ctrl_chk #(
  .NREF(NREF), .FW(FW), .WIN(WIN), .CW(CW), .NOMINAL(NOMINAL)
) u_chk (
  .clk     (clk),
  .rst     (rst),
  .ref_ok  (ref_ok),
  .mode    (mode),
  .sel_ref (sel_ref),
  .freq_out(freq_out),
  .hist_cnt(hist_cnt)
);

// File: tb/test_holdover_ctrl.sv
module test_holdover_ctrl;
  localparam int FW   = 16;
  localparam int DIV  = 3;
  localparam int WIN  = 8;
  localparam int MINS = 4;
  localparam logic [FW-1:0] NOM = 16'h8000;
  localparam longint MASK = (64'd1 << FW) - 1;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [1:0]    ref_ok = 2'b00;
  logic [FW-1:0] freq_in = '0;
  logic          tick_1s = 1'b0;
  logic [1:0]    mode;
  logic [0:0]    sel_ref;
  logic [FW-1:0] freq_out;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  // reference model state
  longint m_acc = 0;
  int     m_cnt = 0;
  int     m_sel = 0;
  int     m_mode = 0;
  longint m_hold = 0;

  holdover_ctrl #(
    .NREF(2), .FW(FW), .TICK_DIV(DIV), .WIN(WIN),
    .MIN_SAMPLES(MINS), .NOMINAL(NOM)
  ) i_holdover_ctrl (
    .clk(clk), .rst(rst), .ref_ok(ref_ok), .freq_in(freq_in),
    .tick_1s(tick_1s), .mode(mode), .sel_ref(sel_ref), .freq_out(freq_out)
  );

  always #2 clk = ~clk;

  function automatic longint m_mean();
    longint q;
    if (m_cnt == 0) return 0;
    q = m_acc / m_cnt;
    return (q > MASK) ? MASK : q;
  endfunction

  function automatic longint exp_freq();
    if (m_mode == 1) return longint'(freq_in);
    if (m_mode == 2) return m_hold;
    return longint'(NOM);
  endfunction

  task automatic chk(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chk_all(string req);
    chk({req, " mode"}, longint'(mode), m_mode);
    chk({req, " sel"},  longint'(sel_ref), m_sel);
    chk({req, " freq"}, longint'(freq_out), exp_freq());
  endtask

  // drive a new reference pattern, update the model, check one cycle later
  task automatic apply(logic [1:0] r, string req);
    ref_ok = r;
    if (r != 2'b00) begin
      int pk = r[0] ? 0 : 1;
      if (pk != m_sel) begin
        m_acc = 0;
        m_cnt = 0;
      end
      m_sel  = pk;
      m_mode = 1;
    end else if (m_mode == 1) begin
      if (m_cnt >= MINS) begin
        m_mode = 2;
        m_hold = m_mean();
      end else begin
        m_mode = 0;
      end
    end
    @(negedge clk);
    chk_all(req);
  endtask

  // one full capture interval with a given sample value
  task automatic take_sample(logic [FW-1:0] s);
    freq_in = s;
    for (int k = 0; k < DIV; k++) begin
      tick_1s = 1'b1;
      @(negedge clk);
      tick_1s = 1'b0;
      repeat (40) @(negedge clk);
    end
    if (m_mode == 1) begin
      if (m_cnt < WIN) begin
        m_acc += longint'(s);
        m_cnt++;
      end else begin
        m_acc = m_acc - m_mean() + longint'(s);
      end
    end
  endtask

  task automatic idle_noise(int n, string req);
    for (int k = 0; k < n; k++) begin
      freq_in = FW'($urandom);
      tick_1s = 1'b1;
      @(negedge clk);
      tick_1s = 1'b0;
      @(negedge clk);
      chk_all(req);
    end
  endtask

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk_all("R1 reset");

    // R2: both valid -> track reference 0
    freq_in = 16'h1234;
    apply(2'b11, "R2 priority");
    freq_in = 16'h4321;
    @(negedge clk);
    chk("R4 freq follow", longint'(freq_out), 64'h4321);

    // fill history on reference 0
    for (int k = 0; k < 6; k++) take_sample(FW'($urandom));
    chk_all("R4 tracking");

    // R3 + R5: lose reference 0 -> switch to 1, history cleared
    apply(2'b10, "R3 failover");
    take_sample(16'h7000);
    take_sample(16'h7100);
    // R7: too few samples -> free-run
    apply(2'b00, "R7 free-run");
    idle_noise(10, "R8 free persist");

    // R10: return to the same reference keeps 2 samples
    apply(2'b10, "R10 same ref");
    for (int k = 0; k < 3; k++) take_sample(16'h7200 + FW'(k));
    apply(2'b00, "R6 holdover");
    chk("R6 mean", longint'(freq_out), (64'h7000 + 64'h7100 + 64'h7200 + 64'h7201 + 64'h7202) / 5);
    idle_noise(15, "R8 hold persist");

    // R5: return on a different reference clears, then saturate (R9)
    apply(2'b01, "R5 new ref");
    for (int k = 0; k < 12; k++)
      take_sample((k % 3 == 0) ? 16'hFFFF : FW'($urandom));
    apply(2'b00, "R9 saturated hold");

    // R5: different ref with only 3 samples -> free-run
    apply(2'b10, "R5 switch");
    for (int k = 0; k < 3; k++) take_sample(FW'($urandom));
    apply(2'b00, "R5 short track");

    // random mix
    for (int it = 0; it < 30; it++) begin
      logic [1:0] r;
      r = 2'($urandom);
      apply(r, "R2 random");
      if (r != 2'b00) begin
        int n = int'($urandom % 4);
        for (int k = 0; k < n; k++) take_sample(FW'($urandom));
        @(negedge clk);
        chk_all("R4 random");
      end else begin
        idle_noise(2, "R8 random");
      end
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule